// File: doc/BRIEF.md
# Direct-Mapped Cache with Allocation Inhibit

This block is a small direct-mapped cache that sits between a requesting core and a slower next-level memory. Reads that hit are answered in the same cycle. Read misses normally fetch the whole line from the next level and then replay the request as a hit. Writes always go through to the next level, and they also update the cached word when the line is resident. An external agent can probe the cache by line address. A probe that hits reports a one-cycle hit indication, and it can also drop the line.

A 32-bit software-writable test register holds a cache-inhibit control in bit 3. When that bit is set, read misses are passed to the next level as single-word reads and nothing is allocated. Lines that are already resident stay valid and keep serving hits. External probes are still handled. The cache is not flushed and not bypassed for hits. Reset clears the test register and every valid bit, so the cache starts enabled and empty.

Top module: `cache_alloc_inhibit`

## Requirements
- R1: After reset, treg_o is zero, every line is invalid (a probe reports no hit and the first read of any address misses), and no next-level request or core ready is asserted.
- R2: A write on the register port loads all 32 bits into treg_o from the next cycle on. Bit 3 of that register is the inhibit control (1 = inhibit), and the other bits have no effect on caching.
- R3: A read that hits a valid line is answered in the same cycle it is presented (no snoop that cycle), with the cached word and no next-level access. A cached word is returned even when next-level memory has since changed without a probe.
- R4: With inhibit clear, a read miss issues exactly LINE_WORDS next-level reads covering the aligned line, marks the line valid with the new tag and then returns the requested word. Later reads within that line hit.
- R5: With inhibit set, a read miss issues exactly one next-level read of the requested address and returns its data. No line is allocated, so a repeat of the same read misses again.
- R6: Setting inhibit leaves resident lines valid. Reads to them keep hitting with the cached data.
- R7: Every write issues exactly one next-level write of the address and data, and the core ready follows its acknowledge. A write hit also updates the cached word. A write miss never allocates, whatever the inhibit setting.
- R8: A probe on snp_line_i with snp_valid_i raises snp_hit_o in the next cycle for one cycle if the line is resident, and leaves it low otherwise. This holds whether inhibit is set or clear.
- R9: A probe that hits with snp_inv_i set invalidates the line. Without snp_inv_i the line stays valid.
- R10: When a probe and an idle-state core request arrive in the same cycle, the probe is handled and the core request is not answered in that cycle. It is served on the following cycle.
- R11: Once raised, a next-level request holds its address and direction steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Core request, held until cpu_ready_o |
| cpu_we_i | input | 1 | Core request is a write |
| cpu_addr_i | input | ADDR_W | Core word address |
| cpu_wdata_i | input | DATA_W | Core write data |
| cpu_ready_o | output | 1 | Core request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_ready_o |
| mem_req_o | output | 1 | Next-level request, held until mem_ack_i |
| mem_we_o | output | 1 | Next-level request is a write |
| mem_addr_o | output | ADDR_W | Next-level word address |
| mem_wdata_o | output | DATA_W | Next-level write data |
| mem_ack_i | input | 1 | Next-level acknowledge, one cycle per word |
| mem_rdata_i | input | DATA_W | Next-level read data, valid with mem_ack_i |
| snp_valid_i | input | 1 | External probe valid |
| snp_inv_i | input | 1 | Probe drops the line on hit |
| snp_line_i | input | ADDR_W-log2(LINE_WORDS) | Probe line address |
| snp_hit_o | output | 1 | Probe hit, one cycle after the probe |
| treg_we_i | input | 1 | Test register write strobe |
| treg_wdata_i | input | 32 | Test register write data |
| treg_o | output | 32 | Test register contents |

## Verification
The assertions assume a well-behaved core and next level. The core holds its request, address and data until it sees ready. The next level pulses mem_ack_i only while mem_req_o is high. Probes may arrive in any state and on any line. The bench keeps to this contract. Its core tasks hold every request until they sample ready and only then drop it. Its memory responder answers only a live request, after a random delay of zero to two cycles. Random probes, inhibit changes and conflicting addresses are mixed freely between core transactions, and in one directed case a probe is made to coincide with a request.

// File: rtl/cia_pkg.sv
package cia_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_BYPASS = 2'd3
  } cia_state_e;

  localparam int unsigned TREG_W      = 32;
  localparam int unsigned INHIBIT_BIT = 3;
endpackage

// File: rtl/cia_treg.sv
module cia_treg
  import cia_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TREG_W-1:0] wdata_i,
  output logic [TREG_W-1:0] q_o,
  output logic              inhibit_o
);
  logic [TREG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i;
  end

  assign q_o       = q;
  assign inhibit_o = q[INHIBIT_BIT];
endmodule

// File: rtl/cia_store.sv
module cia_store #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 8,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // core lookup
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  // probe lookup / invalidate
  input  logic [LINE_W-1:0] sn_line_i,
  output logic              sn_hit_o,
  input  logic              sn_inv_i,
  // data word write
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  // line state update
  input  logic              fill_start_i,
  input  logic              fill_done_i,
  input  logic [LINE_W-1:0] line_i
);
  logic [SETS-1:0]   valid;
  logic [TAG_W-1:0]  tag   [SETS];
  logic [DATA_W-1:0] data_q[SETS*WORDS];

  logic [IDX_W-1:0] lk_idx, sn_idx, ln_idx;
  logic [TAG_W-1:0] lk_tag, sn_tag, ln_tag;

  assign lk_idx = lk_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign sn_idx = sn_line_i[IDX_W-1:0];
  assign sn_tag = sn_line_i[LINE_W-1 -: TAG_W];
  assign ln_idx = line_i[IDX_W-1:0];
  assign ln_tag = line_i[LINE_W-1 -: TAG_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
      end else if (fill_done_i && ln_idx == IDX_W'(s)) begin
        v_q <= 1'b1;
      end else if ((fill_start_i && ln_idx == IDX_W'(s)) ||
                   (sn_inv_i && sn_idx == IDX_W'(s))) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   t_q <= '0;
      else if (fill_done_i && ln_idx == IDX_W'(s))   t_q <= ln_tag;
    end

    assign valid[s] = v_q;
    assign tag[s]   = t_q;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_addr_i[OFF_W+IDX_W-1:0]] <= wr_data_i;
  end

  assign lk_hit_o  = valid[lk_idx] && (tag[lk_idx] == lk_tag);
  assign lk_data_o = data_q[lk_addr_i[OFF_W+IDX_W-1:0]];
  assign sn_hit_o  = valid[sn_idx] && (tag[sn_idx] == sn_tag);
endmodule

// File: rtl/cia_snoop.sv
module cia_snoop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic inv_i,
  input  logic lookup_hit_i,
  output logic inv_o,
  output logic hit_o
);
  logic hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= valid_i && lookup_hit_i;
  end

  assign inv_o = valid_i && inv_i && lookup_hit_i;
  assign hit_o = hit_q;
endmodule

// File: rtl/cia_ctrl.sv
module cia_ctrl
  import cia_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              snp_busy_i,
  input  logic              inhibit_i,
  input  logic              lk_hit_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              st_wr_en_o,
  output logic [ADDR_W-1:0] st_wr_addr_o,
  output logic [DATA_W-1:0] st_wr_data_o,
  output logic              st_fill_start_o,
  output logic              st_fill_done_o,
  output logic [LINE_W-1:0] st_line_o
);
  cia_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic              serve;

  // probe wins the idle slot; core waits one cycle
  assign serve = (state_q == ST_IDLE) && cpu_req_i && !snp_busy_i;

  always_comb begin
    state_d         = state_q;
    cnt_d           = cnt_q;
    cpu_ready_o     = 1'b0;
    cpu_rdata_o     = lk_data_i;
    mem_req_o       = 1'b0;
    mem_we_o        = 1'b0;
    mem_addr_o      = addr_q;
    mem_wdata_o     = wdata_q;
    st_wr_en_o      = 1'b0;
    st_wr_addr_o    = cpu_addr_i;
    st_wr_data_o    = cpu_wdata_i;
    st_fill_start_o = 1'b0;
    st_fill_done_o  = 1'b0;
    st_line_o       = addr_q[ADDR_W-1:OFF_W];

    unique case (state_q)
      ST_IDLE: begin
        st_line_o = cpu_addr_i[ADDR_W-1:OFF_W];
        if (serve) begin
          if (cpu_we_i) begin
            state_d    = ST_WRITE;
            st_wr_en_o = lk_hit_i;
          end else if (lk_hit_i) begin
            cpu_ready_o = 1'b1;
          end else if (inhibit_i) begin
            state_d = ST_BYPASS;
          end else begin
            state_d         = ST_FILL;
            st_fill_start_o = 1'b1;
            cnt_d           = '0;
          end
        end
      end

      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {addr_q[ADDR_W-1:OFF_W], cnt_q};
        if (mem_ack_i) begin
          st_wr_en_o   = 1'b1;
          st_wr_addr_o = {addr_q[ADDR_W-1:OFF_W], cnt_q};
          st_wr_data_o = mem_rdata_i;
          cnt_d        = cnt_q + OFF_W'(1);
          if (cnt_q == OFF_W'(WORDS - 1)) begin
            st_fill_done_o = 1'b1;
            state_d        = ST_IDLE;  // request replays as a hit
          end
        end
      end

      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end

      ST_BYPASS: begin
        mem_req_o   = 1'b1;
        cpu_rdata_o = mem_rdata_i;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (serve) begin
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
      end
    end
  end
endmodule

// File: rtl/cache_alloc_inhibit.sv
module cache_alloc_inhibit
  import cia_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETS       = 8,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cpu_req_i,
  input  logic                                  cpu_we_i,
  input  logic [ADDR_W-1:0]                     cpu_addr_i,
  input  logic [DATA_W-1:0]                     cpu_wdata_i,
  output logic                                  cpu_ready_o,
  output logic [DATA_W-1:0]                     cpu_rdata_o,
  output logic                                  mem_req_o,
  output logic                                  mem_we_o,
  output logic [ADDR_W-1:0]                     mem_addr_o,
  output logic [DATA_W-1:0]                     mem_wdata_o,
  input  logic                                  mem_ack_i,
  input  logic [DATA_W-1:0]                     mem_rdata_i,
  input  logic                                  snp_valid_i,
  input  logic                                  snp_inv_i,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0]  snp_line_i,
  output logic                                  snp_hit_o,
  input  logic                                  treg_we_i,
  input  logic [TREG_W-1:0]                     treg_wdata_i,
  output logic [TREG_W-1:0]                     treg_o
);
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned LINE_W = ADDR_W - OFF_W;

  logic              inhibit;
  logic              lk_hit, sn_lookup_hit, sn_inv;
  logic [DATA_W-1:0] lk_data;
  logic              st_wr_en, st_fill_start, st_fill_done;
  logic [ADDR_W-1:0] st_wr_addr;
  logic [DATA_W-1:0] st_wr_data;
  logic [LINE_W-1:0] st_line;

  cia_treg u_treg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (treg_we_i),
    .wdata_i   (treg_wdata_i),
    .q_o       (treg_o),
    .inhibit_o (inhibit)
  );

  cia_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (SETS),
    .WORDS  (LINE_WORDS)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_addr_i    (cpu_addr_i),
    .lk_hit_o     (lk_hit),
    .lk_data_o    (lk_data),
    .sn_line_i    (snp_line_i),
    .sn_hit_o     (sn_lookup_hit),
    .sn_inv_i     (sn_inv),
    .wr_en_i      (st_wr_en),
    .wr_addr_i    (st_wr_addr),
    .wr_data_i    (st_wr_data),
    .fill_start_i (st_fill_start),
    .fill_done_i  (st_fill_done),
    .line_i       (st_line)
  );

  cia_snoop u_snoop (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (snp_valid_i),
    .inv_i        (snp_inv_i),
    .lookup_hit_i (sn_lookup_hit),
    .inv_o        (sn_inv),
    .hit_o        (snp_hit_o)
  );

  cia_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (LINE_WORDS)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cpu_req_i       (cpu_req_i),
    .cpu_we_i        (cpu_we_i),
    .cpu_addr_i      (cpu_addr_i),
    .cpu_wdata_i     (cpu_wdata_i),
    .cpu_ready_o     (cpu_ready_o),
    .cpu_rdata_o     (cpu_rdata_o),
    .snp_busy_i      (snp_valid_i),
    .inhibit_i       (inhibit),
    .lk_hit_i        (lk_hit),
    .lk_data_i       (lk_data),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_ack_i       (mem_ack_i),
    .mem_rdata_i     (mem_rdata_i),
    .st_wr_en_o      (st_wr_en),
    .st_wr_addr_o    (st_wr_addr),
    .st_wr_data_o    (st_wr_data),
    .st_fill_start_o (st_fill_start),
    .st_fill_done_o  (st_fill_done),
    .st_line_o       (st_line)
  );
endmodule

// File: rtl/cache_alloc_inhibit_chk.sv
module cache_alloc_inhibit_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic              snp_valid_i,
  input logic              snp_hit_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              treg_we_i,
  input logic [31:0]       treg_wdata_i,
  input logic [31:0]       treg_o
);
  a_r2_treg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    treg_we_i |=> treg_o == $past(treg_wdata_i));

  a_r3_ready_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  a_r8_hit_follows_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> $past(snp_valid_i));

  a_r10_probe_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !mem_ack_i) |-> !cpu_ready_o);

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r7_write_is_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
endmodule

bind cache_alloc_inhibit cache_alloc_inhibit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_ready_o  (cpu_ready_o),
  .snp_valid_i  (snp_valid_i),
  .snp_hit_o    (snp_hit_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .treg_we_i    (treg_we_i),
  .treg_wdata_i (treg_wdata_i),
  .treg_o       (treg_o)
);

// File: tb/cache_alloc_inhibit_tb.sv
module cache_alloc_inhibit_tb;
  localparam int AW = 12, DW = 32, SETS = 8, WORDS = 4;
  localparam int OFF_W = $clog2(WORDS), IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - OFF_W - IDX_W, LW = AW - OFF_W;
  localparam int MEM_N = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cpu_req_i = 0, cpu_we_i = 0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic cpu_ready_o;
  logic [DW-1:0] cpu_rdata_o;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic mem_ack_i = 0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic snp_valid_i = 0, snp_inv_i = 0;
  logic [LW-1:0] snp_line_i = '0;
  logic snp_hit_o;
  logic treg_we_i = 0;
  logic [31:0] treg_wdata_i = '0;
  logic [31:0] treg_o;

  always #2 clk = ~clk;

  cache_alloc_inhibit u_dut (.*, .clk_i(clk));

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, lat_cnt = 0;
  logic [DW-1:0] mem [MEM_N];
  bit            m_valid [SETS];
  logic [TAG_W-1:0] m_tag [SETS];
  logic [DW-1:0] m_data [SETS*WORDS];
  bit            m_inh = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [AW-1:0] a);
    return int'(a[OFF_W +: IDX_W]);
  endfunction

  function automatic bit m_hit(input logic [AW-1:0] a);
    return m_valid[idx_of(a)] && m_tag[idx_of(a)] == a[AW-1 -: TAG_W];
  endfunction

  function automatic logic [DW-1:0] init_word(input int i);
    return (i * 32'h0101_0107) ^ 32'hA5A5_0000;
  endfunction

  // next-level responder: 0..2 cycle latency
  initial begin
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (lat_cnt == 0) begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin mem[mem_addr_o] = mem_wdata_o; n_wr++; end
          else begin mem_rdata_i = mem[mem_addr_o]; n_rd++; end
          lat_cnt = int'($urandom % 3);
        end else lat_cnt--;
      end
    end
  end

  task automatic cpu_read(input logic [AW-1:0] a, input string req);
    bit hit = m_hit(a);
    logic [DW-1:0] exp = hit ? m_data[a[OFF_W+IDX_W-1:0]] : mem[a];
    int r0 = n_rd, w0 = n_wr, lat = 0, exp_rd;
    logic [DW-1:0] got;
    exp_rd = hit ? 0 : (m_inh ? 1 : WORDS);
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = 0; cpu_addr_i = a;
    #1;
    while (!cpu_ready_o) begin @(negedge clk); #1; lat++; end
    got = cpu_rdata_o;
    @(negedge clk);
    cpu_req_i = 0;
    check(got == exp, {req, " read data"}, got, exp);
    check(n_rd - r0 == exp_rd && n_wr == w0, {req, " next-level reads"}, n_rd - r0, exp_rd);
    if (hit) check(lat == 0, {req, " hit latency"}, lat, 0);
    if (!hit && !m_inh) begin
      m_valid[idx_of(a)] = 1;
      m_tag[idx_of(a)] = a[AW-1 -: TAG_W];
      for (int w = 0; w < WORDS; w++)
        m_data[idx_of(a)*WORDS + w] = mem[{a[AW-1:OFF_W], OFF_W'(w)}];
    end
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    int r0 = n_rd, w0 = n_wr;
    if (m_hit(a)) m_data[a[OFF_W+IDX_W-1:0]] = d;
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = 1; cpu_addr_i = a; cpu_wdata_i = d;
    #1;
    while (!cpu_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req_i = 0; cpu_we_i = 0;
    check(n_wr - w0 == 1 && n_rd == r0, {req, " write-through count"}, n_wr - w0, 1);
    check(mem[a] == d, {req, " write-through data"}, mem[a], d);
  endtask

  task automatic probe(input logic [LW-1:0] ln, input bit inv, input string req);
    logic [AW-1:0] a = {ln, OFF_W'(0)};
    bit exp = m_hit(a);
    @(negedge clk);
    snp_valid_i = 1; snp_inv_i = inv; snp_line_i = ln;
    @(negedge clk);
    snp_valid_i = 0; snp_inv_i = 0;
    #1 check(snp_hit_o == exp, {req, " probe hit"}, snp_hit_o, exp);
    @(negedge clk);
    #1 check(snp_hit_o == 0, {req, " probe hit one cycle"}, snp_hit_o, 0);
    if (exp && inv) m_valid[idx_of(a)] = 0;
  endtask

  task automatic set_treg(input logic [31:0] v, input string req);
    @(negedge clk);
    treg_we_i = 1; treg_wdata_i = v;
    @(negedge clk);
    treg_we_i = 0;
    #1 check(treg_o == v, {req, " register value"}, treg_o, v);
    m_inh = v[3];
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] old_w, got;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEM_N; i++) mem[i] = init_word(i);
    for (int s = 0; s < SETS; s++) begin m_valid[s] = 0; m_tag[s] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    // R1 reset state
    check(treg_o == 0, "R1 treg", treg_o, 0);
    check(!mem_req_o && !cpu_ready_o && !snp_hit_o, "R1 idle outputs",
          {mem_req_o, cpu_ready_o, snp_hit_o}, 0);
    probe(LW'(12'h010 >> OFF_W), 0, "R1");
    // R4 fill, R3 hits
    cpu_read(12'h010, "R1 R4 first miss fills");
    cpu_read(12'h011, "R3 R4 hit in filled line");
    cpu_read(12'h013, "R3 hit");
    old_w = mem[12'h012];
    mem[12'h012] = 32'hDEAD_0012;
    cpu_read(12'h012, "R3 stale cached word");
    // R2 inhibit at bit 3, R6 resident lines keep hitting
    set_treg(32'h0000_0008, "R2");
    cpu_read(12'h012, "R6 hit while inhibited");
    cpu_read(12'h040, "R5 inhibited miss");
    cpu_read(12'h040, "R5 no allocation");
    // R8 / R9 probes while inhibited
    probe(LW'(12'h010 >> OFF_W), 0, "R8 R9 keep");
    cpu_read(12'h011, "R9 line kept");
    probe(LW'(12'h010 >> OFF_W), 1, "R8 R9 invalidate");
    cpu_read(12'h012, "R9 invalidated line misses");
    probe(LW'(12'h040 >> OFF_W), 0, "R8 miss");
    // R7 writes
    set_treg(32'h0000_0000, "R2 clear");
    cpu_read(12'h020, "R4 fill");
    set_treg(32'hFFFF_FFFF, "R2 all ones");
    cpu_write(12'h021, 32'h1234_5678, "R7 write hit");
    cpu_read(12'h021, "R7 hit sees new data");
    cpu_write(12'h050, 32'h0BAD_F00D, "R7 write miss");
    cpu_read(12'h050, "R7 write miss not allocated");
    // R10 probe and request together
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = 0; cpu_addr_i = 12'h022;
    snp_valid_i = 1; snp_inv_i = 0; snp_line_i = LW'(12'h060 >> OFF_W);
    #1 check(cpu_ready_o == 0, "R10 request stalled", cpu_ready_o, 0);
    @(negedge clk);
    snp_valid_i = 0;
    #1 check(cpu_ready_o == 1, "R10 served next cycle", cpu_ready_o, 1);
    got = cpu_rdata_o;
    check(got == m_data[12'h022 & (SETS*WORDS-1)], "R10 data", got, m_data[12'h022 & (SETS*WORDS-1)]);
    check(snp_hit_o == 0, "R10 probe miss", snp_hit_o, 0);
    @(negedge clk);
    cpu_req_i = 0;
    // R2 other bits ignored
    set_treg(32'hFFFF_FFF7, "R2 bit3 clear");
    cpu_read(12'h070, "R2 R4 allocates with other bits set");
    cpu_read(12'h071, "R2 R3 hit");
    mem[12'h012] = old_w;
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 10);
      logic [AW-1:0] a = AW'($urandom % 256);
      if (op < 5)      cpu_read(a, "R3 R4 R5 random read");
      else if (op < 7) cpu_write(a, $urandom, "R7 random write");
      else if (op < 9) probe(a[AW-1:OFF_W], bit'($urandom % 2), "R8 R9 random probe");
      else             set_treg($urandom, "R2 random");
    end
    finish_run();
  end
endmodule